// File: doc/BRIEF.md
# Shared-Bus Ownership Arbiter Interface

This block is the requester side of a shared parallel bus on which an external arbiter picks the next owner. When the cycle sequencer asks for a bus cycle, the block pulls an active-low request line and waits. It waits for the arbiter's active-low grant and for the bus to be free, meaning that no other master is holding the busy line or the lock line low. It then hands a one-clock start strobe to the sequencer. The sequencer runs the cycle and reports its end with a done strobe.

Busy and lock are open, shared lines. The block splits each one into a sampled input level and a driven output level, with one common output enable. While the block owns the bus it drives busy low for each cycle. Lock copies busy during ordinary cycles. For an atomic read-modify-write, the sequencer flags each cycle of the sequence except the last. Lock then stays low across the gap between cycles, and the block keeps ownership without asking the arbiter again. A high grant takes every bus-owned driver to high impedance, whatever state the block is in.

Top module: `bus_own_arbiter`

## Requirements
- R1: While reset is asserted, busReqN=1, cycStart=0, ownBus=0, busOwnOe=0, busBusyOutN=1 and busLockOutN=1.
- R2: When idle, a high cycReq sampled at a clock edge makes busReqN low from that edge on. busReqN stays low until the bus is acquired.
- R3: While the block is requesting, an edge that sees busGntN=0, busBusyInN=1 and busLockInN=1 all at once starts a cycle. After that edge: cycStart=1 for exactly one clock, busReqN=1, ownBus=1, busBusyOutN=0.
- R4: While the block is requesting, a high grant, a low busBusyInN or a low busLockInN blocks the start. The block keeps busReqN=0 and ownBus=0.
- R5: During a cycle whose lockSeq was 0 at its start, busLockOutN follows busBusyOutN and is driven low.
- R6: When a cycle that had lockSeq=1 at its start ends (cycDone=1), the block keeps ownBus=1. It drives busBusyOutN=1 and keeps busLockOutN=0. busReqN stays 1.
- R7: In the locked gap between cycles, a high cycReq starts the next cycle on the next edge with cycStart=1. No request is raised: busReqN stays 1.
- R8: When a cycle with lockSeq=0 ends, the block releases the bus on the next edge. ownBus=0, busBusyOutN=1 and busLockOutN=1.
- R9: busOwnOe is 1 only when the block owns the bus and busGntN=0. A high grant forces busOwnOe=0 in the same clock.
- R10: If cycReq falls while the block is still requesting, busReqN returns to 1 on the next edge and no cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cycReq | input | 1 | Sequencer wants a bus cycle |
| lockSeq | input | 1 | Requested cycle is a non-final member of an atomic sequence |
| cycDone | input | 1 | Sequencer ends the current cycle |
| busGntN | input | 1 | Active-low grant from the external arbiter |
| busBusyInN | input | 1 | Sampled level of the shared busy line |
| busLockInN | input | 1 | Sampled level of the shared lock line |
| busReqN | output | 1 | Active-low bus request |
| cycStart | output | 1 | One-clock strobe: sequencer may run the cycle |
| ownBus | output | 1 | Block currently owns the bus |
| busOwnOe | output | 1 | Enable for busy, lock and all other bus-owned drivers |
| busBusyOutN | output | 1 | Value driven on the busy line when enabled |
| busLockOutN | output | 1 | Value driven on the lock line when enabled |

## Verification
The bench keeps a pending request waiting against each blocker in turn: a high grant, another master's busy, and a lock held low while busy is high. A design that looked only at grant would start a cycle on top of another master. The bench ends a locked cycle in the very clock it started, and then issues the next member at once. A design that re-arbitrated would pull busReqN low, and one that dropped lock in the gap would let a second master break the atomic sequence. It also lifts the grant mid-cycle to check that the drivers float while ownership is kept, and it withdraws a request before any grant arrives.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ASK    = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_HOLD   = 2'd3
  } ownState_t;

  // Strobes from control to datapath, describing the state about to be entered.
  typedef struct packed {
    logic reqOn;
    logic startCyc;
    logic ownOn;
    logic busyLow;
    logic lockLow;
  } arbStrobe_t;

endpackage

// File: rtl/bus_own_ctrl.sv
module bus_own_ctrl
  import bus_own_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cycReq,
  input  logic       cycDone,
  input  logic       busGntN,
  input  logic       busBusyInN,
  input  logic       busLockInN,
  input  logic       lockHeld,
  output arbStrobe_t strobes
);

  ownState_t stateQ, stateNext;
  logic busFree;

  // The shared lines are only meaningful here while another master may own them.
  assign busFree = !busGntN && busBusyInN && busLockInN;

  always_comb begin
    stateNext = stateQ;
    unique case (stateQ)
      ST_IDLE:   if (cycReq) stateNext = ST_ASK;
      ST_ASK: begin
        if (!cycReq)      stateNext = ST_IDLE;
        else if (busFree) stateNext = ST_ACTIVE;
      end
      ST_ACTIVE: if (cycDone) stateNext = lockHeld ? ST_HOLD : ST_IDLE;
      ST_HOLD:   if (cycReq) stateNext = ST_ACTIVE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNext;
  end

  always_comb begin
    strobes.reqOn    = (stateNext == ST_ASK);
    strobes.startCyc = (stateNext == ST_ACTIVE) && (stateQ != ST_ACTIVE);
    strobes.ownOn    = (stateNext == ST_ACTIVE) || (stateNext == ST_HOLD);
    strobes.busyLow  = (stateNext == ST_ACTIVE);
    strobes.lockLow  = (stateNext == ST_ACTIVE) || (stateNext == ST_HOLD);
  end

  // R10: a request that is withdrawn never turns into a cycle
  assert_cancel_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ASK && !cycReq) |=> !strobes.ownOn || stateQ != ST_ACTIVE);

endmodule

// File: rtl/bus_own_dp.sv
module bus_own_dp
  import bus_own_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  arbStrobe_t strobes,
  input  logic       lockSeq,
  input  logic       busGntN,
  output logic       lockHeld,
  output logic       busReqN,
  output logic       cycStart,
  output logic       ownBus,
  output logic       busOwnOe,
  output logic       busBusyOutN,
  output logic       busLockOutN
);

  logic reqNq, startQ, ownQ, busyNq, lockNq, lockHeldQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqNq     <= 1'b1;
      startQ    <= 1'b0;
      ownQ      <= 1'b0;
      busyNq    <= 1'b1;
      lockNq    <= 1'b1;
      lockHeldQ <= 1'b0;
    end else begin
      reqNq  <= !strobes.reqOn;
      startQ <= strobes.startCyc;
      ownQ   <= strobes.ownOn;
      busyNq <= !strobes.busyLow;
      lockNq <= !strobes.lockLow;
      if (strobes.startCyc) lockHeldQ <= lockSeq;
    end
  end

  assign lockHeld    = lockHeldQ;
  assign busReqN     = reqNq;
  assign cycStart    = startQ;
  assign ownBus      = ownQ;
  assign busOwnOe    = ownQ && !busGntN;
  assign busBusyOutN = busyNq;
  assign busLockOutN = lockNq;

  // R3: the request is already released in the start clock
  assert_req_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    startQ |-> reqNq);

  // R3: the start strobe is a single clock wide
  assert_one_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    startQ |=> !startQ);

  // R5: whenever busy is driven low, lock is driven low as well
  assert_lock_follow_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ownQ && !busyNq) |-> !lockNq);

  // R7: an owner never requests the bus again
  assert_hold_no_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    ownQ |-> reqNq);

endmodule

// File: rtl/bus_own_arbiter.sv
module bus_own_arbiter
  import bus_own_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic cycReq,
  input  logic lockSeq,
  input  logic cycDone,
  input  logic busGntN,
  input  logic busBusyInN,
  input  logic busLockInN,
  output logic busReqN,
  output logic cycStart,
  output logic ownBus,
  output logic busOwnOe,
  output logic busBusyOutN,
  output logic busLockOutN
);

  arbStrobe_t strobes;
  logic lockHeld;

  bus_own_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .cycReq     (cycReq),
    .cycDone    (cycDone),
    .busGntN    (busGntN),
    .busBusyInN (busBusyInN),
    .busLockInN (busLockInN),
    .lockHeld   (lockHeld),
    .strobes    (strobes)
  );

  bus_own_dp dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .lockSeq     (lockSeq),
    .busGntN     (busGntN),
    .lockHeld    (lockHeld),
    .busReqN     (busReqN),
    .cycStart    (cycStart),
    .ownBus      (ownBus),
    .busOwnOe    (busOwnOe),
    .busBusyOutN (busBusyOutN),
    .busLockOutN (busLockOutN)
  );

  // R3: ownership gained from a pending request implies grant and a free bus at that edge
  assert_start_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ownBus) && $past(!busReqN)) |-> $past(!busGntN && busBusyInN && busLockInN));

  // R4: while requesting, a blocked bus keeps the block off the bus
  assert_blocked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!busReqN && (busGntN || !busBusyInN || !busLockInN)) |=> !ownBus);

endmodule

// File: tb/bus_own_arbiter_tb.sv
`timescale 1ns/1ps
module bus_own_arbiter_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycReq = 1'b0, lockSeq = 1'b0, cycDone = 1'b0;
  logic busGntN = 1'b1, busBusyInN = 1'b1, busLockInN = 1'b1;
  logic busReqN, cycStart, ownBus, busOwnOe, busBusyOutN, busLockOutN;

  int errCount = 0;
  int chkCount = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bus_own_arbiter dut_i (
    .clk(clk), .rstN(rstN), .cycReq(cycReq), .lockSeq(lockSeq), .cycDone(cycDone),
    .busGntN(busGntN), .busBusyInN(busBusyInN), .busLockInN(busLockInN),
    .busReqN(busReqN), .cycStart(cycStart), .ownBus(ownBus), .busOwnOe(busOwnOe),
    .busBusyOutN(busBusyOutN), .busLockOutN(busLockOutN)
  );

  // inputs {cycReq,lockSeq,cycDone,busGntN,busBusyInN,busLockInN}
  // expected {busReqN,cycStart,ownBus,busOwnOe,busBusyOutN,busLockOutN} after the next edge
  localparam int NVEC = 25;
  localparam logic [11:0] VEC [NVEC] = '{
    {6'b000111, 6'b100011}, // 0  idle
    {6'b100111, 6'b000011}, // 1  request
    {6'b100111, 6'b000011}, // 2  grant high
    {6'b100001, 6'b000011}, // 3  other master busy
    {6'b100010, 6'b000011}, // 4  other master lock
    {6'b100011, 6'b111100}, // 5  start
    {6'b100011, 6'b101100}, // 6  cycle continues
    {6'b001011, 6'b100011}, // 7  unlocked end
    {6'b110011, 6'b000011}, // 8  locked request
    {6'b110011, 6'b111100}, // 9  locked start
    {6'b011011, 6'b101110}, // 10 gap
    {6'b000011, 6'b101110}, // 11 gap held
    {6'b100000, 6'b111100}, // 12 next member, no re-arbitration
    {6'b001011, 6'b100011}, // 13 final end
    {6'b100111, 6'b000011}, // 14 request
    {6'b000111, 6'b100011}, // 15 withdrawn
    {6'b100011, 6'b000011}, // 16 request
    {6'b100011, 6'b111100}, // 17 start
    {6'b100111, 6'b101000}, // 18 grant lifted mid-cycle
    {6'b001011, 6'b100011}, // 19 end
    {6'b110011, 6'b000011}, // 20 locked request
    {6'b110011, 6'b111100}, // 21 start
    {6'b111011, 6'b101110}, // 22 done in start cycle, still requesting
    {6'b100011, 6'b111100}, // 23 immediate next member
    {6'b001011, 6'b100011}  // 24 final end
  };

  function automatic string vecTag(int idx);
    case (idx)
      0: return "R1";
      1, 8, 14, 16, 20: return "R2";
      2, 3, 4: return "R4";
      5, 9, 17, 21: return "R3";
      6: return "R5";
      7, 13, 19, 24: return "R8";
      10, 11, 22: return "R6";
      12, 23: return "R7";
      15: return "R10";
      default: return "R9";
    endcase
  endfunction

  task automatic checkOut(input string tag, input logic [5:0] expv);
    logic [5:0] act;
    act = {busReqN, cycStart, ownBus, busOwnOe, busBusyOutN, busLockOutN};
    chkCount++;
    if (act !== expv) begin
      errCount++;
      $display("FAIL %s: outputs actual=%b expected=%b", tag, act, expv);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errCount++;
      chkCount++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errCount, chkCount);
      $finish;
    end
  end

  initial begin
    // R1: outputs while reset is held
    repeat (3) @(negedge clk);
    checkOut("R1", 6'b100011);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {cycReq, lockSeq, cycDone, busGntN, busBusyInN, busLockInN} = VEC[i][11:6];
      @(posedge clk);
      #1;
      checkOut(vecTag(i), VEC[i][5:0]);
    end

    // R9: grant lifted while idle leaves drivers off
    @(negedge clk);
    {cycReq, lockSeq, cycDone, busGntN, busBusyInN, busLockInN} = 6'b000111;
    #1;
    checkOut("R9", 6'b100011);

    // R1: reset taken in the middle of an owned cycle
    @(negedge clk);
    {cycReq, lockSeq, cycDone, busGntN, busBusyInN, busLockInN} = 6'b110011;
    @(posedge clk);
    @(posedge clk);
    #1;
    checkOut("R3", 6'b111100);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    checkOut("R1", 6'b100011);
    @(negedge clk);
    cycReq = 1'b0;
    lockSeq = 1'b0;
    rstN = 1'b1;
    @(posedge clk);
    #1;
    checkOut("R1", 6'b100011);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end

endmodule